// File: doc/BRIEF.md
# Floating-Point Reservation Station Bank with Result-Bus Snooping

This block is the waiting area of an out-of-order floating-point scheduler. It has five slots. Three serve the adder class, which handles add and subtract. Two serve the multiplier class, which handles multiply and divide. When an instruction issues, it claims the lowest free slot of its class. For each of its two sources the slot receives either a usable value or the tag of the unit that will produce that value. The slot then watches a single shared result bus. When a tag it is waiting for appears on the bus, it copies the value into the pending source.

A slot whose two sources are both resolved is sent to its execution unit, when that unit can take work. The execution units are modelled only as latency counters:

- The adder unit is fully pipelined with 4 execute cycles.
- The multiplier unit is fully pipelined with 7 execute cycles.
- The divider is not pipelined, takes 24 execute cycles, and is shared by the multiplier-class slots.

When a slot finishes executing, it offers its tag, opcode and captured operands on a finish port. An outside bus arbiter computes the result and places it on the result bus. The slot is released in the cycle its own tag is broadcast. A broadcast may also carry tags from producers outside the bank, such as load buffers.

Top module: `fp_rsv_bank`

## Requirements
- R1: After reset, every slot is free. An issue of either class is accepted with the lowest tag of that class. No dispatch or finish is signalled.
- R2: The slots use tags 1 to 3 for the adder class and tags 4 to 5 for the multiplier class. Tag 0 means that a source is already resolved. Opcode bit 1 selects the class. The opcodes are: 00 add, 01 sub, 10 mul, 11 div. `iss_ready` is high exactly when the class of `iss_op` has a free slot. `iss_tag` is then the lowest free tag of that class.
- R3: A pending source takes the bus value in the cycle its tag is broadcast. The slot dispatches no earlier than the next cycle.
- R4: A source issued with a nonzero tag equal to the tag broadcast in that same cycle takes the broadcast value and is treated as resolved.
- R5: Each class dispatches at most one slot per cycle. The slot chosen is the lowest-numbered slot whose sources are both resolved and which is not yet dispatched.
- R6: Add and subtract are pipelined with 4 execute cycles. The dispatch cycle is the first of these. The slot offers its result 4 cycles after dispatch. Adder dispatches may occur in consecutive cycles.
- R7: Multiply is pipelined with 7 execute cycles. It can dispatch while a divide is running.
- R8: Divide takes 24 execute cycles and is not pipelined. A later divide dispatches no earlier than 24 cycles after the previous one. Multiply slots behind a blocked divide still dispatch.
- R9: The finish port shows the lowest-numbered finished slot, with its opcode and captured operands. A finished slot stays offered until its tag is broadcast. It is freed at that broadcast and can be issued into again in the next cycle.
- R10: A broadcast whose tag matches no pending source changes no operand. A source that was resolved at issue keeps the value given at issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 2 | Opcode of the issuing instruction |
| iss_qj | input | TAG_W | Producer tag of source j, 0 if resolved |
| iss_vj | input | DATA_W | Value of source j when resolved |
| iss_qk | input | TAG_W | Producer tag of source k, 0 if resolved |
| iss_vk | input | DATA_W | Value of source k when resolved |
| iss_ready | output | 1 | A slot of the requested class is free |
| iss_tag | output | TAG_W | Tag given to the issuing instruction |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TAG_W | Producer tag on the result bus |
| cdb_value | input | DATA_W | Value on the result bus |
| disp_add_valid | output | 1 | An adder-class slot dispatches this cycle |
| disp_add_tag | output | TAG_W | Tag of the dispatching adder slot |
| disp_mul_valid | output | 1 | A multiplier-class slot dispatches this cycle |
| disp_mul_tag | output | TAG_W | Tag of the dispatching multiplier slot |
| disp_mul_op | output | 2 | Opcode of the dispatching multiplier slot |
| fin_valid | output | 1 | A slot has finished and waits for the bus |
| fin_tag | output | TAG_W | Tag of the offered finished slot |
| fin_op | output | 2 | Opcode of the offered slot |
| fin_vj | output | DATA_W | Captured source j of the offered slot |
| fin_vk | output | DATA_W | Captured source k of the offered slot |

## Verification
Two situations are the hardest to reach from the ports.

The first is an instruction that issues in the exact cycle the tag it names is broadcast. To reach it, the stimulus holds an external producer tag pending and issues an instruction that names it. In that same cycle it places the tag on the bus. The random phase also lets new sources name slots that are finishing in that cycle.

The second is a divide that is held back while a multiply behind it goes ahead. This needs two ready divides, or a divide followed by a multiply, arriving inside the 24-cycle divider window. The stimulus issues two divides directly. It then mixes divides into long random runs in which the bus also stalls now and then. Those stalls keep finished slots waiting, which tests the hold behaviour.

// File: rtl/fprs_pkg.sv
package fprs_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_DIV = 2'b11
  } fop_e;

  typedef enum logic [1:0] {
    ST_FREE = 2'b00,
    ST_WAIT = 2'b01,
    ST_EXEC = 2'b10,
    ST_DONE = 2'b11
  } rs_st_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/fprs_pick.sv
module fprs_pick #(
  parameter  int N  = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);

  // lowest index wins
  always_comb begin
    any    = 1'b0;
    idx    = '0;
    onehot = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
    if (any) onehot[idx] = 1'b1;
  end

endmodule

// File: rtl/fprs_entry.sv
module fprs_entry
  import fprs_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 4,
  parameter int MY_TAG  = 1,
  parameter int ADD_LAT = 4,
  parameter int MUL_LAT = 7,
  parameter int DIV_LAT = 24,
  parameter int CNT_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [1:0]        ld_op,
  input  logic [TAG_W-1:0]  ld_qj,
  input  logic [DATA_W-1:0] ld_vj,
  input  logic [TAG_W-1:0]  ld_qk,
  input  logic [DATA_W-1:0] ld_vk,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              go,
  output logic              busy_o,
  output logic              ready_o,
  output logic              exec_o,
  output logic              done_o,
  output logic [1:0]        op_o,
  output logic [DATA_W-1:0] vj_o,
  output logic [DATA_W-1:0] vk_o
);

  localparam logic [TAG_W-1:0] OWN = TAG_W'(MY_TAG);

  rs_st_e            st_q, st_d;
  logic [1:0]        op_q;
  logic [TAG_W-1:0]  qj_q, qj_d, qk_q, qk_d;
  logic [DATA_W-1:0] vj_q, vj_d, vk_q, vk_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, lat_m2;
  logic              ld_fire, hit_j, hit_k, byp_j, byp_k;
  logic              j_en, k_en, cnt_en;

  assign ld_fire = ld_en && (st_q == ST_FREE);
  assign hit_j   = (st_q == ST_WAIT) && cdb_valid && (qj_q != '0) && (cdb_tag == qj_q);
  assign hit_k   = (st_q == ST_WAIT) && cdb_valid && (qk_q != '0) && (cdb_tag == qk_q);
  assign byp_j   = cdb_valid && (ld_qj != '0) && (cdb_tag == ld_qj);
  assign byp_k   = cdb_valid && (ld_qk != '0) && (cdb_tag == ld_qk);

  // execute length minus two: dispatch cycle and done transition
  always_comb begin
    case (op_q)
      OP_ADD, OP_SUB: lat_m2 = CNT_W'(ADD_LAT - 2);
      OP_MUL:         lat_m2 = CNT_W'(MUL_LAT - 2);
      default:        lat_m2 = CNT_W'(DIV_LAT - 2);
    endcase
  end

  // source j next value
  always_comb begin
    qj_d = qj_q;
    vj_d = vj_q;
    if (ld_fire) begin
      qj_d = byp_j ? '0 : ld_qj;
      vj_d = byp_j ? cdb_value : ld_vj;
    end else if (hit_j) begin
      qj_d = '0;
      vj_d = cdb_value;
    end
  end

  // source k next value
  always_comb begin
    qk_d = qk_q;
    vk_d = vk_q;
    if (ld_fire) begin
      qk_d = byp_k ? '0 : ld_qk;
      vk_d = byp_k ? cdb_value : ld_vk;
    end else if (hit_k) begin
      qk_d = '0;
      vk_d = cdb_value;
    end
  end

  // state sequencing
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_FREE: if (ld_en) st_d = ST_WAIT;
      ST_WAIT: if (go) begin
        st_d  = ST_EXEC;
        cnt_d = lat_m2;
      end
      ST_EXEC: begin
        if (cnt_q == '0) st_d = ST_DONE;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: if (cdb_valid && (cdb_tag == OWN)) st_d = ST_FREE;
    endcase
  end

  assign j_en   = ld_fire || hit_j;
  assign k_en   = ld_fire || hit_k;
  assign cnt_en = (st_q == ST_EXEC) || ((st_q == ST_WAIT) && go);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_FREE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (ld_fire) op_q <= ld_op;
  end

  always_ff @(posedge clk) begin
    if (j_en) begin
      qj_q <= qj_d;
      vj_q <= vj_d;
    end
  end

  always_ff @(posedge clk) begin
    if (k_en) begin
      qk_q <= qk_d;
      vk_q <= vk_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o  = (st_q != ST_FREE);
  assign ready_o = (st_q == ST_WAIT) && (qj_q == '0) && (qk_q == '0);
  assign exec_o  = (st_q == ST_EXEC);
  assign done_o  = (st_q == ST_DONE);
  assign op_o    = op_q;
  assign vj_o    = vj_q;
  assign vk_o    = vk_q;

endmodule

// File: rtl/fp_rsv_bank.sv
module fp_rsv_bank
  import fprs_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 4,
  parameter int N_ADD   = 3,
  parameter int N_MUL   = 2,
  parameter int ADD_LAT = 4,
  parameter int MUL_LAT = 7,
  parameter int DIV_LAT = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [1:0]        iss_op,
  input  logic [TAG_W-1:0]  iss_qj,
  input  logic [DATA_W-1:0] iss_vj,
  input  logic [TAG_W-1:0]  iss_qk,
  input  logic [DATA_W-1:0] iss_vk,
  output logic              iss_ready,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  output logic              disp_add_valid,
  output logic [TAG_W-1:0]  disp_add_tag,
  output logic              disp_mul_valid,
  output logic [TAG_W-1:0]  disp_mul_tag,
  output logic [1:0]        disp_mul_op,
  output logic              fin_valid,
  output logic [TAG_W-1:0]  fin_tag,
  output logic [1:0]        fin_op,
  output logic [DATA_W-1:0] fin_vj,
  output logic [DATA_W-1:0] fin_vk
);

  localparam int N_ENT   = N_ADD + N_MUL;
  localparam int MAX_LAT = max3(ADD_LAT, MUL_LAT, DIV_LAT);
  localparam int CNT_W   = (MAX_LAT > 2) ? $clog2(MAX_LAT) : 1;
  localparam int AIW     = (N_ADD > 1) ? $clog2(N_ADD) : 1;
  localparam int MIW     = (N_MUL > 1) ? $clog2(N_MUL) : 1;
  localparam int EIW     = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [N_ENT-1:0]  busy_v, ready_v, exec_v, done_v, ld_v, go_v;
  logic [1:0]        op_a [N_ENT];
  logic [DATA_W-1:0] vj_a [N_ENT];
  logic [DATA_W-1:0] vk_a [N_ENT];

  logic             add_free, mul_free, add_go_any, mul_go_any, fin_any;
  logic [AIW-1:0]   add_free_idx, add_go_idx;
  logic [MIW-1:0]   mul_free_idx, mul_go_idx;
  logic [EIW-1:0]   fin_idx;
  logic [N_ADD-1:0] add_free_oh, add_go_oh;
  logic [N_MUL-1:0] mul_free_oh, mul_go_oh, mul_elig;
  logic [N_ENT-1:0] fin_oh;
  logic             iss_mul, iss_fire, div_busy;

  // ---------------- slot allocation ----------------
  fprs_pick #(.N(N_ADD)) u_free_add (
    .req(~busy_v[N_ADD-1:0]), .any(add_free), .idx(add_free_idx), .onehot(add_free_oh)
  );
  fprs_pick #(.N(N_MUL)) u_free_mul (
    .req(~busy_v[N_ENT-1:N_ADD]), .any(mul_free), .idx(mul_free_idx), .onehot(mul_free_oh)
  );

  assign iss_mul   = iss_op[1];
  assign iss_ready = iss_mul ? mul_free : add_free;
  assign iss_tag   = iss_mul ? (TAG_W'(N_ADD + 1) + TAG_W'(mul_free_idx))
                             : (TAG_W'(1) + TAG_W'(add_free_idx));
  assign iss_fire  = iss_valid && iss_ready;

  always_comb begin
    ld_v = '0;
    if (iss_fire) begin
      if (iss_mul) ld_v[N_ENT-1:N_ADD] = mul_free_oh;
      else         ld_v[N_ADD-1:0]     = add_free_oh;
    end
  end

  // ---------------- dispatch ----------------
  fprs_pick #(.N(N_ADD)) u_go_add (
    .req(ready_v[N_ADD-1:0]), .any(add_go_any), .idx(add_go_idx), .onehot(add_go_oh)
  );

  // divider occupied while any multiplier-class slot executes a divide
  always_comb begin
    div_busy = 1'b0;
    for (int j = 0; j < N_MUL; j++) begin
      if (exec_v[N_ADD + j] && (op_a[N_ADD + j] == OP_DIV)) div_busy = 1'b1;
    end
  end

  always_comb begin
    for (int j = 0; j < N_MUL; j++) begin
      mul_elig[j] = ready_v[N_ADD + j] && !((op_a[N_ADD + j] == OP_DIV) && div_busy);
    end
  end

  fprs_pick #(.N(N_MUL)) u_go_mul (
    .req(mul_elig), .any(mul_go_any), .idx(mul_go_idx), .onehot(mul_go_oh)
  );

  assign go_v           = {mul_go_oh, add_go_oh};
  assign disp_add_valid = add_go_any;
  assign disp_add_tag   = TAG_W'(1) + TAG_W'(add_go_idx);
  assign disp_mul_valid = mul_go_any;
  assign disp_mul_tag   = TAG_W'(N_ADD + 1) + TAG_W'(mul_go_idx);
  assign disp_mul_op    = op_a[N_ADD + int'(mul_go_idx)];

  // ---------------- slots ----------------
  for (genvar g = 0; g < N_ENT; g++) begin : g_slot
    fprs_entry #(
      .DATA_W(DATA_W), .TAG_W(TAG_W), .MY_TAG(g + 1),
      .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT), .CNT_W(CNT_W)
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .ld_en(ld_v[g]), .ld_op(iss_op),
      .ld_qj(iss_qj), .ld_vj(iss_vj), .ld_qk(iss_qk), .ld_vk(iss_vk),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
      .go(go_v[g]),
      .busy_o(busy_v[g]), .ready_o(ready_v[g]), .exec_o(exec_v[g]), .done_o(done_v[g]),
      .op_o(op_a[g]), .vj_o(vj_a[g]), .vk_o(vk_a[g])
    );
  end

  // ---------------- finish port ----------------
  fprs_pick #(.N(N_ENT)) u_fin (
    .req(done_v), .any(fin_any), .idx(fin_idx), .onehot(fin_oh)
  );

  assign fin_valid = fin_any;
  assign fin_tag   = TAG_W'(1) + TAG_W'(fin_idx);
  assign fin_op    = op_a[fin_idx];
  assign fin_vj    = vj_a[fin_idx];
  assign fin_vk    = vk_a[fin_idx];

endmodule

// File: rtl/fp_rsv_bank_chk.sv
module fp_rsv_bank_chk #(
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 4,
  parameter int N_ADD   = 3,
  parameter int N_MUL   = 2,
  parameter int ADD_LAT = 4,
  parameter int MUL_LAT = 7,
  parameter int DIV_LAT = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              iss_valid,
  input logic [1:0]        iss_op,
  input logic [TAG_W-1:0]  iss_qj,
  input logic [DATA_W-1:0] iss_vj,
  input logic [TAG_W-1:0]  iss_qk,
  input logic [DATA_W-1:0] iss_vk,
  input logic              iss_ready,
  input logic [TAG_W-1:0]  iss_tag,
  input logic              cdb_valid,
  input logic [TAG_W-1:0]  cdb_tag,
  input logic [DATA_W-1:0] cdb_value,
  input logic              disp_add_valid,
  input logic [TAG_W-1:0]  disp_add_tag,
  input logic              disp_mul_valid,
  input logic [TAG_W-1:0]  disp_mul_tag,
  input logic [1:0]        disp_mul_op,
  input logic              fin_valid,
  input logic [TAG_W-1:0]  fin_tag,
  input logic [1:0]        fin_op,
  input logic [DATA_W-1:0] fin_vj,
  input logic [DATA_W-1:0] fin_vk
);

  localparam int N_ENT = N_ADD + N_MUL;
  localparam int GW    = $clog2(DIV_LAT + 1) + 1;

  logic [GW-1:0] div_gap;
  logic          div_seen;
  logic          div_go;

  assign div_go = disp_mul_valid && (disp_mul_op == 2'b11);

  // cycles since the last divide dispatch, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_gap  <= '0;
      div_seen <= 1'b0;
    end else if (div_go) begin
      div_gap  <= GW'(1);
      div_seen <= 1'b1;
    end else if (div_gap < GW'(DIV_LAT)) begin
      div_gap  <= div_gap + 1'b1;
    end
  end

  p_tag_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_ready |-> (iss_op[1] ? ((int'(iss_tag) > N_ADD) && (int'(iss_tag) <= N_ENT))
                             : ((int'(iss_tag) >= 1) && (int'(iss_tag) <= N_ADD))));

  p_no_same_cycle_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && !iss_op[1]) |-> !(disp_add_valid && (disp_add_tag == iss_tag)));

  p_no_early_fin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    disp_add_valid |=> !(fin_valid && (fin_tag == $past(disp_add_tag))));

  p_div_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (div_go && div_seen) |-> (div_gap >= GW'(DIV_LAT)));

  p_fin_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_valid && !(cdb_valid && (cdb_tag == fin_tag))) |=> fin_valid);

  p_free_on_bcast_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_valid && cdb_valid && (cdb_tag == fin_tag)) |=> !(fin_valid && (fin_tag == $past(fin_tag))));

endmodule

bind fp_rsv_bank fp_rsv_bank_chk #(
  .DATA_W(DATA_W), .TAG_W(TAG_W), .N_ADD(N_ADD), .N_MUL(N_MUL),
  .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT)
) u_chk (.*);

// File: tb/fp_rsv_bank_tb.sv
module fp_rsv_bank_tb;

  localparam int DW   = 32;
  localparam int TW   = 4;
  localparam int NA   = 3;
  localparam int NE   = 5;
  localparam int NEVER = 1 << 30;

  logic          clk, rst_n;
  logic          iss_valid;
  logic [1:0]    iss_op;
  logic [TW-1:0] iss_qj, iss_qk, iss_tag;
  logic [DW-1:0] iss_vj, iss_vk;
  logic          iss_ready;
  logic          cdb_valid;
  logic [TW-1:0] cdb_tag;
  logic [DW-1:0] cdb_value;
  logic          disp_add_valid, disp_mul_valid, fin_valid;
  logic [TW-1:0] disp_add_tag, disp_mul_tag, fin_tag;
  logic [1:0]    disp_mul_op, fin_op;
  logic [DW-1:0] fin_vj, fin_vk;

  fp_rsv_bank u_dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit ended = 0;

  // bench model of the slots, indexed by tag
  bit          r_busy [16];
  int          r_op   [16];
  int          r_qj   [16], r_qk [16];
  logic [DW-1:0] r_vj [16], r_vk [16];
  int          r_kj   [16], r_kk [16];   // 0 given at issue, 1 from bus, 2 bypass
  int          r_rdy  [16];
  int          r_disp [16];
  bit          ext_pend [16];
  int          last_div = -1000;

  function automatic int lat(input int op);
    return (op < 2) ? 4 : (op == 2) ? 7 : 24;
  endfunction

  function automatic logic [DW-1:0] calc(input int op, input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a * b;
      default: return a ^ b;
    endcase
  endfunction

  function automatic string kind_lbl(input int k);
    return (k == 0) ? "R10" : (k == 1) ? "R3" : "R4";
  endfunction

  function automatic string fin_lbl(input int op);
    return (op < 2) ? "R6" : (op == 2) ? "R7" : "R8";
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s cycle=%0d actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  task automatic step(input bit want, input logic [1:0] op, input int jt, input int kt, input int bc);
    int ef, bt, ea, em, fr, lo, hi;
    logic [DW-1:0] bv, vjd, vkd;
    @(negedge clk);
    ef = 0;
    for (int t = NE; t >= 1; t--)
      if (r_busy[t] && r_disp[t] >= 0 && cyc >= r_disp[t] + lat(r_op[t])) ef = t;
    bt = 0;
    if (bc == -1) begin
      if (ef != 0) bt = ef;
      else for (int t = 11; t >= 8; t--) if (ext_pend[t]) bt = t;
    end else if (bc == -2) begin
      if (ef != 0 && ($urandom % 8) != 0) bt = ef;
      else if (($urandom % 3) == 0) bt = 8 + int'($urandom % 8);
    end else bt = bc;
    bv  = (bt >= 1 && bt <= NE) ? calc(r_op[bt], r_vj[bt], r_vk[bt]) : $urandom;
    vjd = $urandom;
    vkd = $urandom;
    cdb_valid = (bt != 0);
    cdb_tag   = TW'(bt);
    cdb_value = bv;
    iss_valid = want;
    iss_op    = op;
    iss_qj    = (jt < 0) ? '0 : TW'(jt);
    iss_qk    = (kt < 0) ? '0 : TW'(kt);
    iss_vj    = vjd;
    iss_vk    = vkd;
    #1;
    // R2: allocation
    lo = op[1] ? NA + 1 : 1;
    hi = op[1] ? NE : NA;
    fr = 0;
    for (int t = hi; t >= lo; t--) if (!r_busy[t]) fr = t;
    chk("R2", "iss_ready", iss_ready, fr != 0);
    if (fr != 0) chk("R2", "iss_tag", iss_tag, fr);
    // R5: adder dispatch
    ea = 0;
    for (int t = NA; t >= 1; t--)
      if (r_busy[t] && r_disp[t] < 0 && r_rdy[t] <= cyc) ea = t;
    chk("R5", "disp_add_valid", disp_add_valid, ea != 0);
    if (ea != 0) chk("R5", "disp_add_tag", disp_add_tag, ea);
    // R7/R8: multiplier-class dispatch
    em = 0;
    for (int t = NE; t > NA; t--)
      if (r_busy[t] && r_disp[t] < 0 && r_rdy[t] <= cyc &&
          !(r_op[t] == 3 && cyc < last_div + 24)) em = t;
    chk((em != 0 && r_op[em] == 3) ? "R8" : "R7", "disp_mul_valid", disp_mul_valid, em != 0);
    if (em != 0) begin
      chk(r_op[em] == 3 ? "R8" : "R7", "disp_mul_tag", disp_mul_tag, em);
      chk(r_op[em] == 3 ? "R8" : "R7", "disp_mul_op", disp_mul_op, r_op[em]);
    end
    // R9 and latency: finish port
    chk(ef != 0 ? fin_lbl(r_op[ef]) : "R9", "fin_valid", fin_valid, ef != 0);
    if (ef != 0) begin
      chk("R9", "fin_tag", fin_tag, ef);
      chk("R9", "fin_op", fin_op, r_op[ef]);
      chk(kind_lbl(r_kj[ef]), "fin_vj", fin_vj, r_vj[ef]);
      chk(kind_lbl(r_kk[ef]), "fin_vk", fin_vk, r_vk[ef]);
    end
    // model update: broadcast
    if (bt != 0) begin
      for (int t = 1; t <= NE; t++) begin
        if (r_busy[t] && r_qj[t] == bt) begin r_qj[t] = 0; r_vj[t] = bv; r_kj[t] = 1; end
        if (r_busy[t] && r_qk[t] == bt) begin r_qk[t] = 0; r_vk[t] = bv; r_kk[t] = 1; end
        if (r_busy[t] && r_qj[t] == 0 && r_qk[t] == 0 && r_rdy[t] == NEVER) r_rdy[t] = cyc + 1;
      end
      if (bt <= NE) r_busy[bt] = 0;
      else ext_pend[bt] = 0;
    end
    // model update: issue
    if (want && fr != 0) begin
      r_busy[fr] = 1; r_op[fr] = op; r_disp[fr] = -1;
      if (jt <= 0)       begin r_qj[fr] = 0;  r_vj[fr] = vjd; r_kj[fr] = 0; end
      else if (jt == bt) begin r_qj[fr] = 0;  r_vj[fr] = bv;  r_kj[fr] = 2; end
      else               begin r_qj[fr] = jt; r_vj[fr] = 'x;  r_kj[fr] = 1; end
      if (kt <= 0)       begin r_qk[fr] = 0;  r_vk[fr] = vkd; r_kk[fr] = 0; end
      else if (kt == bt) begin r_qk[fr] = 0;  r_vk[fr] = bv;  r_kk[fr] = 2; end
      else               begin r_qk[fr] = kt; r_vk[fr] = 'x;  r_kk[fr] = 1; end
      r_rdy[fr] = (r_qj[fr] == 0 && r_qk[fr] == 0) ? cyc + 1 : NEVER;
    end
    // model update: dispatch
    if (ea != 0) r_disp[ea] = cyc;
    if (em != 0) begin
      r_disp[em] = cyc;
      if (r_op[em] == 3) last_div = cyc;
    end
    cyc++;
  endtask

  function automatic bit anything_left();
    for (int t = 1; t < 16; t++) if (r_busy[t] || ext_pend[t]) return 1;
    return 0;
  endfunction

  task automatic drain();
    for (int n = 0; n < 3000 && anything_left(); n++) step(0, 2'b00, -1, -1, -1);
  endtask

  function automatic int pick_src();
    int r, t;
    r = int'($urandom % 20);
    if (r < 10) return -1;
    if (r < 17) begin
      t = 1 + int'($urandom % 5);
      return r_busy[t] ? t : -1;
    end
    t = 8 + int'($urandom % 4);
    return ext_pend[t] ? t : -1;
  endfunction

  initial begin
    void'($urandom(32'd7321));
    for (int t = 0; t < 16; t++) begin
      r_busy[t] = 0; ext_pend[t] = 0; r_rdy[t] = NEVER; r_disp[t] = -1;
    end
    rst_n = 1'b0; iss_valid = 0; iss_op = 0; iss_qj = 0; iss_qk = 0;
    iss_vj = 0; iss_vk = 0; cdb_valid = 0; cdb_tag = 0; cdb_value = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    iss_op = 2'b00; #1;
    chk("R1", "iss_ready add", iss_ready, 1);
    chk("R1", "iss_tag add", iss_tag, 1);
    iss_op = 2'b10; #1;
    chk("R1", "iss_ready mul", iss_ready, 1);
    chk("R1", "iss_tag mul", iss_tag, 4);
    chk("R1", "fin_valid", fin_valid, 0);
    chk("R1", "disp_add_valid", disp_add_valid, 0);
    chk("R1", "disp_mul_valid", disp_mul_valid, 0);

    // R2 R5 R6: fill the adder class behind one external producer
    ext_pend[8] = 1;
    step(1, 2'b00, 8, -1, 0);
    step(1, 2'b01, -1, 8, 0);
    step(1, 2'b00, 8, 8, 0);
    step(1, 2'b00, -1, -1, 0);      // class full, must be refused
    step(0, 2'b00, -1, -1, 8);      // release all three at once
    drain();

    // R8: two ready divides plus a multiply behind them
    step(1, 2'b11, -1, -1, 0);
    step(1, 2'b11, -1, -1, 0);
    repeat (5) step(0, 2'b00, -1, -1, 0);
    drain();
    step(1, 2'b11, -1, -1, 0);
    step(1, 2'b10, -1, -1, 0);
    drain();

    // R4: issue in the same cycle as the producer broadcast
    ext_pend[9] = 1;
    step(1, 2'b00, 9, -1, 9);
    ext_pend[10] = 1;
    step(1, 2'b10, -1, 10, 10);
    drain();

    // R10: unrelated broadcast while a source waits
    ext_pend[11] = 1;
    step(1, 2'b01, 11, -1, 0);
    step(0, 2'b00, -1, -1, 13);
    step(0, 2'b00, -1, -1, 12);
    step(0, 2'b00, -1, -1, 11);
    drain();

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [1:0] rop;
      if (($urandom % 6) == 0) ext_pend[8 + ($urandom % 4)] = 1;
      r = int'($urandom % 12);
      rop = (r < 4) ? 2'b00 : (r < 7) ? 2'b01 : (r < 11) ? 2'b10 : 2'b11;
      step(($urandom % 4) != 0, rop, pick_src(), pick_src(), -2);
    end
    drain();
    chk("R9", "all slots returned", anything_left(), 0);

    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++;
      fails++;
      $display("FAIL watchdog cycle=%0d actual=running expected=finished", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule